// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one binary down-counting timer channel. A timer clock enable advances it, and a register interface loads it with a count value and a mode through a single strobe. From the count, the mode and a gate input it produces one output waveform. The six waveforms are: a terminal-count flag, a retriggerable one-shot, a rate pulse, a square wave, a software strobe and a hardware strobe. The live count value drives an output on every cycle, so the surrounding interface can read it or latch it.

A loaded value of zero stands for the full range (2^CNT_W, which is 65536 at the default width). Each load restarts the elapsed-tick measurement. The gate input is asynchronous. It passes through a synchroniser and an edge detector, and a rising edge restarts the measurement in the retriggerable modes. Mode codes 6 and 7 act as aliases of the two periodic modes.

Top module: `timer_channel`

## Requirements
- R1: After reset the channel is in mode 3 with a reload value of 2^CNT_W. out_o reads 1 and count_o reads 0.
- R2: A load_i pulse captures mode_i and count_val_i. A count value of 0 is taken as 2^CNT_W. The elapsed tick count d returns to 0 at that edge. A load wins over a tick or a gate edge in the same cycle.
- R3: Mode 0: out_o = (d >= N). count_o = (N - d) mod 2^CNT_W, so the count keeps wrapping after it reaches zero.
- R4: Mode 1: out_o = (d < N). count_o = (N - d) mod 2^CNT_W. A gate rising edge sets d to 0.
- R5: Mode 2: out_o is 1 only when d mod N = 0 and d != 0. count_o = (N - d mod N) mod 2^CNT_W.
- R6: Mode 3: out_o = (d mod N < (N+1)/2). count_o = (N - (2d mod N)) mod 2^CNT_W, so the count falls by two per tick.
- R7: Mode 4: out_o is 1 only when d = N. count_o = (N - d) mod 2^CNT_W. A gate edge has no effect.
- R8: Mode 5: the output and count behave as in mode 4, and a gate rising edge sets d to 0.
- R9: Mode codes 6 and 7 behave exactly as modes 2 and 3, gate retrigger included.
- R10: d advances by one only at a clock edge where tick_i is 1. In all other cycles out_o and count_o hold, unless a load or a retrigger occurs.
- R11: A gate rising edge takes effect at the (SYNC_STAGES+1)-th clock edge, counting the first edge that samples gate_i high as edge 1. That gate_i sample must have followed a low sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer clock enable, one elapsed tick per cycle when high |
| load_i | input | 1 | Load strobe capturing mode_i and count_val_i |
| mode_i | input | 3 | Operating mode code 0..7 |
| count_val_i | input | CNT_W | Count value, 0 meaning 2^CNT_W |
| gate_i | input | 1 | Asynchronous gate input |
| out_o | output | 1 | Channel output waveform |
| count_o | output | CNT_W | Live count value |

## Verification
The bench builds the channel with its defaults, CNT_W = 16 and SYNC_STAGES = 2. Full width lets it run a zero load for the whole 65536-tick span and see the single terminal edge and the wrap of the count. Two synchroniser stages fix the gate retrigger latency at three edges, and the reference model follows that latency exactly. Short counts of both parities (3 to 7) exercise the periodic modes over many periods: odd square-wave halves, rate pulses and retriggers in the middle of a period.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [2:0] {
    MODE_TC     = 3'd0,
    MODE_ONESHOT = 3'd1,
    MODE_RATE   = 3'd2,
    MODE_SQUARE = 3'd3,
    MODE_SW_STB = 3'd4,
    MODE_HW_STB = 3'd5
  } mode_e;

  // codes 6/7 fold onto the periodic modes
  function automatic mode_e norm_mode(input logic [2:0] code);
    logic [2:0] c;
    c = (code[2:1] == 2'b11) ? {1'b0, code[1:0]} : code;
    return mode_e'(c);
  endfunction

  function automatic logic gate_retrig(input mode_e m);
    return (m == MODE_ONESHOT) || (m == MODE_RATE) ||
           (m == MODE_SQUARE) || (m == MODE_HW_STB);
  endfunction
endpackage

// File: rtl/timer_gate_sync.sv
module timer_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= gate_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], gate_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             gate_rise_i,
  output mode_e            mode_o,
  output logic [CNT_W:0]   reload_o,
  output logic [CNT_W-1:0] down_o,
  output logic [CNT_W:0]   phase_o,
  output logic             passed_o,
  output logic             hit_o,
  output logic             started_o
);
  localparam logic [CNT_W:0]   FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  mode_e            mode_q;
  logic [CNT_W:0]   reload_q, phase_q;
  logic [CNT_W-1:0] down_q;
  logic             passed_q, hit_q, started_q;
  logic             restart;

  assign restart = gate_rise_i & gate_retrig(mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_SQUARE;
      reload_q  <= FULL;
      down_q    <= '0;
      phase_q   <= '0;
      passed_q  <= 1'b0;
      hit_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (load_i) begin
      mode_q    <= norm_mode(mode_i);
      reload_q  <= (load_val_i == '0) ? FULL : {1'b0, load_val_i};
      down_q    <= load_val_i;
      phase_q   <= '0;
      passed_q  <= 1'b0;
      hit_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (restart) begin
      down_q    <= reload_q[CNT_W-1:0];
      phase_q   <= '0;
      passed_q  <= 1'b0;
      hit_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (tick_i) begin
      down_q    <= down_q - ONE;
      phase_q   <= (phase_q == reload_q - 1'b1) ? '0 : phase_q + 1'b1;
      started_q <= 1'b1;
      // first arrival at d == N
      if (down_q == ONE && !passed_q) begin
        passed_q <= 1'b1;
        hit_q    <= 1'b1;
      end else begin
        hit_q    <= 1'b0;
      end
    end
  end

  assign mode_o    = mode_q;
  assign reload_o  = reload_q;
  assign down_o    = down_q;
  assign phase_o   = phase_q;
  assign passed_o  = passed_q;
  assign hit_o     = hit_q;
  assign started_o = started_q;
endmodule

// File: rtl/timer_out_decode.sv
module timer_out_decode
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  mode_e            mode_i,
  input  logic [CNT_W:0]   reload_i,
  input  logic [CNT_W-1:0] down_i,
  input  logic [CNT_W:0]   phase_i,
  input  logic             passed_i,
  input  logic             hit_i,
  input  logic             started_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int EW = CNT_W + 2;

  logic [EW-1:0] n_e, ph_e, dbl, half, sq_diff, rate_diff;

  always_comb begin
    n_e  = EW'(reload_i);
    ph_e = EW'(phase_i);
    dbl  = ph_e << 1;
    if (dbl >= n_e) dbl = dbl - n_e;
    half      = (n_e + EW'(1)) >> 1;
    sq_diff   = n_e - dbl;
    rate_diff = n_e - ph_e;
  end

  always_comb begin
    out_o   = 1'b0;
    count_o = down_i;
    unique case (mode_i)
      MODE_TC:      out_o = passed_i;
      MODE_ONESHOT: out_o = ~passed_i;
      MODE_RATE: begin
        out_o   = (phase_i == '0) && started_i;
        count_o = rate_diff[CNT_W-1:0];
      end
      MODE_SQUARE: begin
        out_o   = (ph_e < half);
        count_o = sq_diff[CNT_W-1:0];
      end
      MODE_SW_STB, MODE_HW_STB: out_o = hit_i;
      default: out_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] count_val_i,
  input  logic             gate_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  logic             gate_rise;
  mode_e            mode_q;
  logic [CNT_W:0]   reload_q, phase_q;
  logic [CNT_W-1:0] down_q;
  logic             passed_q, hit_q, started_q;

  timer_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  timer_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .load_i      (load_i),
    .mode_i      (mode_i),
    .load_val_i  (count_val_i),
    .gate_rise_i (gate_rise),
    .mode_o      (mode_q),
    .reload_o    (reload_q),
    .down_o      (down_q),
    .phase_o     (phase_q),
    .passed_o    (passed_q),
    .hit_o       (hit_q),
    .started_o   (started_q)
  );

  timer_out_decode #(.CNT_W(CNT_W)) u_dec (
    .mode_i    (mode_q),
    .reload_i  (reload_q),
    .down_i    (down_q),
    .phase_i   (phase_q),
    .passed_i  (passed_q),
    .hit_i     (hit_q),
    .started_i (started_q),
    .out_o     (out_o),
    .count_o   (count_o)
  );
endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             load_i,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] count_val_i,
  input logic             out_o,
  input logic [CNT_W-1:0] count_o
);
  logic [2:0] cur_mode;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cur_mode <= 3'd3;
    else if (load_i) cur_mode <= mode_i;

  assert_zero_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && count_val_i == '0 && mode_i == 3'd0 |=> count_o == '0 && !out_o);

  assert_tc_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_mode == 3'd0 && out_o && !load_i |=> out_o);

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode == 3'd4 || cur_mode == 3'd5) && out_o && tick_i && !load_i |=> !out_o);

  assert_hold_no_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode == 3'd0 || cur_mode == 3'd4) && !tick_i && !load_i
    |=> $stable(count_o) && $stable(out_o));
endmodule

bind timer_channel timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .load_i      (load_i),
  .mode_i      (mode_i),
  .count_val_i (count_val_i),
  .out_o       (out_o),
  .count_o     (count_o)
);

// File: tb/timer_channel_tb.sv
module timer_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0, load = 1'b0, gate = 1'b0;
  logic [2:0]       mode = 3'd0;
  logic [CNT_W-1:0] cval = '0;
  logic             out;
  logic [CNT_W-1:0] cnt;

  int    checks = 0, errors = 0;
  string phase  = "R1";
  bit    done   = 1'b0;

  // reference state
  longint m_n, m_d;
  int     m_mode;
  bit     m_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .load_i (load),
    .mode_i (mode), .count_val_i (cval), .gate_i (gate),
    .out_o (out), .count_o (cnt)
  );

  function automatic int eff(int m);
    return (m >= 6) ? m - 4 : m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3; m_n = 65536; m_d = 0;
      m_hist.delete();
      for (int i = 0; i <= SYNC; i++) m_hist.push_back(1'b0);
    end else begin
      bit rise;
      int e;
      rise = m_hist[SYNC-1] && !m_hist[SYNC];
      e = eff(m_mode);
      if (load) begin
        m_mode = int'(mode);
        m_n = (cval == 0) ? 65536 : longint'(cval);
        m_d = 0;
      end else if (rise && (e == 1 || e == 2 || e == 3 || e == 5)) m_d = 0;
      else if (tick) m_d++;
      m_hist.push_front(gate);
      void'(m_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int  e;
      bit  xo;
      longint xc;
      e = eff(m_mode);
      case (e)
        0: begin xo = (m_d >= m_n); xc = (m_n - m_d) & 16'hffff; end
        1: begin xo = (m_d < m_n);  xc = (m_n - m_d) & 16'hffff; end
        2: begin xo = (m_d % m_n == 0) && (m_d != 0); xc = (m_n - m_d % m_n) & 16'hffff; end
        3: begin xo = (m_d % m_n) < ((m_n + 1) / 2); xc = (m_n - (2 * m_d) % m_n) & 16'hffff; end
        default: begin xo = (m_d == m_n); xc = (m_n - m_d) & 16'hffff; end
      endcase
      checks += 2;
      if (out !== xo) begin
        errors++;
        $display("FAIL %s out_o actual=%0b expected=%0b (mode %0d d=%0d)", phase, out, xo, m_mode, m_d);
      end
      if (cnt !== xc[15:0]) begin
        errors++;
        $display("FAIL %s count_o actual=%0d expected=%0d (mode %0d d=%0d)", phase, cnt, xc, m_mode, m_d);
      end
    end
  end

  task automatic run(int n, int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (i % every == 0);
    end
  endtask

  task automatic do_load(int m, int v, bit with_tick);
    @(negedge clk);
    load = 1'b1; mode = 3'(m); cval = 16'(v); tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_gate(int hi, int lo);
    @(negedge clk); gate = 1'b1;
    run(hi, 1);
    @(negedge clk); gate = 1'b0;
    run(lo, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    checks++;
    if (out !== 1'b1 || cnt !== 16'd0) begin
      errors++;
      $display("FAIL R1 reset actual=%0b/%0d expected=1/0", out, cnt);
    end
    phase = "R6"; run(12, 1);
    phase = "R3"; do_load(0, 5, 1'b0); run(12, 1);
    phase = "R10"; do_load(0, 4, 1'b0); run(20, 3);
    phase = "R2"; do_load(0, 0, 1'b1); run(65540, 1);
    phase = "R2"; do_load(4, 7, 1'b1); run(3, 1);
    phase = "R4"; do_load(1, 6, 1'b0); run(10, 1);
    phase = "R11"; pulse_gate(4, 3); run(8, 1);
    phase = "R5"; do_load(2, 4, 1'b0); run(14, 1);
    phase = "R11"; pulse_gate(2, 2); run(9, 2);
    phase = "R6"; do_load(3, 5, 1'b0); run(16, 1);
    phase = "R6"; do_load(3, 6, 1'b0); run(16, 1); pulse_gate(3, 1); run(8, 1);
    phase = "R7"; do_load(4, 3, 1'b0); run(3, 1); pulse_gate(2, 2); run(6, 1);
    phase = "R8"; do_load(5, 4, 1'b0); run(6, 1); pulse_gate(2, 1); run(8, 1);
    phase = "R9"; do_load(6, 3, 1'b0); run(10, 1); pulse_gate(2, 1); run(5, 1);
    phase = "R9"; do_load(7, 4, 1'b0); run(10, 1); pulse_gate(2, 1); run(6, 1);
    phase = "R10"; do_load(3, 7, 1'b0); run(24, 4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule